// File: doc/BRIEF.md
# Graphics DMA Address Cutoff Guard

This block decides whether a graphics DMA access to a physical address may proceed. A single 32-bit protection register holds three cutoff counts and one lock bit. Each cutoff count fences off the top end of a memory region in fixed-size steps, growing downward from that region's end. Three regions use a cutoff: an original main-memory region, a main-memory extension placed directly above it, and a small secondary memory. The lock bit closes a work-RAM window entirely. The old-region count also closes the first step of the extension region whenever it is nonzero.

The access checker takes an address qualified by a valid strobe. One clock later it returns a registered result valid and a deny flag. The deny flag is the OR of every rule, and an address that lies in no region is always allowed. A plain write port loads the register, and a read port shows its present value at all times. Region bases, ends and step sizes are parameters. By default the old main region is 0x20000000–0x27FFFFFF, the extension is 0x28000000–0x2FFFFFFF, the secondary memory is 0x1F000000–0x1F3FFFFF and the work RAM is 0x1FF80000–0x1FFFFFFF.

Top module: `dmaprot_guard`

## Requirements
- R1: When `cfg_wr_en` is high at a rising edge, `cfg_wr_data[10:0]` is stored. From the next cycle `cfg_rd_data` shows the stored bits, and `cfg_rd_data[31:11]` always reads zero. Without a write, `cfg_rd_data` holds its value.
- R2: After reset the register reads 0, `chk_valid` and `chk_deny` are low, and every access is allowed.
- R3: With old cutoff x = bits [3:0] nonzero, addresses from 0x28000000 − 0x800000·x up to 0x27FFFFFF are denied. x = 0 denies nothing.
- R4: With extension cutoff y = bits [7:4] nonzero, addresses from 0x30000000 − 0x800000·y up to 0x2FFFFFFF are denied. y = 0 denies nothing.
- R5: While x is nonzero, addresses 0x28000000–0x287FFFFF are also denied, whatever the value of y.
- R6: Bit 8 set denies every address in 0x1FF80000–0x1FFFFFFF. Bit 8 clear leaves that window open.
- R7: With secondary cutoff z = bits [10:9] nonzero, addresses from 0x1F400000 − 0x100000·z up to 0x1F3FFFFF are denied.
- R8: Addresses 0x20000000–0x207FFFFF are never denied, for any register value.
- R9: Deny is the OR of R3–R7 with all cutoffs active together. Addresses outside all four regions are always allowed.
- R10: `chk_valid` is `acc_valid` delayed by one cycle. `chk_deny` is the verdict for the address presented in that earlier cycle, and is low whenever `chk_valid` is low.
- R11: An access presented in the same cycle as a register write is judged against the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Protection register write strobe |
| cfg_wr_data | input | 32 | Protection register write value |
| cfg_rd_data | output | 32 | Present protection register value |
| acc_valid | input | 1 | Access address qualifier |
| acc_addr | input | 32 | Physical address of the DMA access |
| chk_valid | output | 1 | Verdict valid, one cycle after the access |
| chk_deny | output | 1 | 1 = access refused, 0 = permitted |

## Verification
A register write and an access check can land on the same clock edge. The bench provokes this by presenting an address just below the old-region end together with a write that switches the old cutoff on, and again together with a write that switches it off. The verdict must follow the value held before each write. A behavioural model in the bench updates its copy of the register only after it has judged the access on that edge. The stored value is then checked through the read port in the cycle that follows.

// File: rtl/dmaprot_pkg.sv
// Package: field layout of the DMA cutoff protection register.
// Assumes a 32-bit register with the used fields packed in the low bits.
package dmaprot_pkg;
    localparam int REG_W      = 32;
    localparam int OLD_CW     = 4;
    localparam int NEW_CW     = 4;
    localparam int SEC_CW     = 2;
    localparam int OLD_LSB    = 0;
    localparam int NEW_LSB    = OLD_LSB + OLD_CW;
    localparam int WRAM_BIT   = NEW_LSB + NEW_CW;
    localparam int SEC_LSB    = WRAM_BIT + 1;
    localparam int USED_W     = SEC_LSB + SEC_CW;

    typedef struct packed {
        logic [SEC_CW-1:0] sec_cut;
        logic              wram_lock;
        logic [NEW_CW-1:0] new_cut;
        logic [OLD_CW-1:0] old_cut;
    } prot_fields_t;
endpackage

// File: rtl/dmaprot_cfg_reg.sv
// Module: protection register storage. Keeps only the low USED_W bits;
// upper bits read as zero. Assumes single-cycle writes, no byte enables.
module dmaprot_cfg_reg #(
    parameter int REG_W  = 32,
    parameter int USED_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [USED_W-1:0] fields
);
    localparam logic [REG_W-1:0] KEEP_MASK = REG_W'((1 << USED_W) - 1);

    logic [USED_W-1:0] store_q;

    // Capture the used field bits on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (wr_en) begin
            store_q <= wr_data[USED_W-1:0];
        end
    end

    // Present the stored bits with zero-filled upper bits.
    always_comb begin
        rd_data = REG_W'(store_q);
        fields  = store_q;
    end

    // R1
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & KEEP_MASK));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/dmaprot_cutoff_rule.sv
// Module: top-down cutoff rule for one region. A nonzero count c denies
// [TOP - STEP*c, TOP), clamped at BASE. An optional head window of HEAD_LEN
// bytes at BASE is denied while head_en is high. TOP is exclusive.
module dmaprot_cutoff_rule #(
    parameter int              ADDR_W   = 32,
    parameter int              CW       = 4,
    parameter logic [ADDR_W:0] BASE     = 33'h0_2000_0000,
    parameter logic [ADDR_W:0] TOP      = 33'h0_2800_0000,
    parameter logic [ADDR_W:0] STEP     = 33'h0_0080_0000,
    parameter logic [ADDR_W:0] HEAD_LEN = 33'h0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     cut,
    input  logic              head_en,
    output logic              deny
);
    localparam int              SW       = ADDR_W + CW + 1;
    localparam logic [SW-1:0]   SPAN_MAX = SW'(TOP - BASE);
    localparam logic [ADDR_W:0] HEAD_END = BASE + HEAD_LEN;

    logic [SW-1:0]   span;
    logic [ADDR_W:0] floor_addr;
    logic [ADDR_W:0] a_ext;
    logic            in_region;
    logic            tail_hit;
    logic            head_hit;

    // Compute the lowest protected address for the present count.
    always_comb begin
        span = SW'(STEP) * SW'(cut);
        if (span > SPAN_MAX) begin
            floor_addr = BASE;
        end else begin
            floor_addr = TOP - span[ADDR_W:0];
        end
    end

    // Compare the address against the region and the cutoff floor.
    always_comb begin
        a_ext     = {1'b0, addr};
        in_region = (a_ext >= BASE) && (a_ext < TOP);
        tail_hit  = (cut != '0) && in_region && (a_ext >= floor_addr);
    end

    // Head window exists only when a nonzero length is configured.
    generate
        if (HEAD_LEN != '0) begin : g_head
            always_comb head_hit = head_en && (a_ext >= BASE) && (a_ext < HEAD_END);
        end else begin : g_nohead
            always_comb head_hit = head_en && 1'b0;
        end
    endgenerate

    // Combine the two hit sources.
    always_comb deny = tail_hit || head_hit;

    // R3 R4 R7
    always_comb begin
        zero_cut_open_chk: assert (!((cut == '0) && !head_en) || !deny);
    end
endmodule

// File: rtl/dmaprot_window_rule.sv
// Module: all-or-nothing window rule. While lock is high every address in
// [BASE, TOP) is denied. TOP is exclusive.
module dmaprot_window_rule #(
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W:0] BASE   = 33'h0_1FF8_0000,
    parameter logic [ADDR_W:0] TOP    = 33'h0_2000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock,
    output logic              deny
);
    logic [ADDR_W:0] a_ext;

    // Window membership qualified by the lock bit.
    always_comb begin
        a_ext = {1'b0, addr};
        deny  = lock && (a_ext >= BASE) && (a_ext < TOP);
    end

    // R6
    always_comb begin
        unlocked_open_chk: assert (lock || !deny);
    end
endmodule

// File: rtl/dmaprot_guard.sv
// Module: graphics DMA address cutoff guard (top). Holds the protection
// register, evaluates all region rules on the presented address and
// registers the verdict one cycle later. An access in the same cycle as a
// write sees the pre-write register value.
module dmaprot_guard
    import dmaprot_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W:0] OLD_BASE  = 33'h0_2000_0000,
    parameter logic [ADDR_W:0] OLD_TOP   = 33'h0_2800_0000,
    parameter logic [ADDR_W:0] NEW_BASE  = 33'h0_2800_0000,
    parameter logic [ADDR_W:0] NEW_TOP   = 33'h0_3000_0000,
    parameter logic [ADDR_W:0] MAIN_STEP = 33'h0_0080_0000,
    parameter logic [ADDR_W:0] SEC_BASE  = 33'h0_1F00_0000,
    parameter logic [ADDR_W:0] SEC_TOP   = 33'h0_1F40_0000,
    parameter logic [ADDR_W:0] SEC_STEP  = 33'h0_0010_0000,
    parameter logic [ADDR_W:0] WRAM_BASE = 33'h0_1FF8_0000,
    parameter logic [ADDR_W:0] WRAM_TOP  = 33'h0_2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic [REG_W-1:0]  cfg_rd_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              chk_valid,
    output logic              chk_deny
);
    localparam int NRULE = 4;

    prot_fields_t      fld;
    logic [USED_W-1:0] fld_bits;
    logic [NRULE-1:0]  rule_deny;
    logic              deny_any;
    logic [ADDR_W:0]   a_ext;
    logic              outside_all;
    logic              old_head;

    dmaprot_cfg_reg #(.REG_W(REG_W), .USED_W(USED_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .fields  (fld_bits)
    );

    // Map the raw stored bits onto named fields.
    always_comb fld = prot_fields_t'(fld_bits);

    dmaprot_cutoff_rule #(.ADDR_W(ADDR_W), .CW(OLD_CW), .BASE(OLD_BASE),
        .TOP(OLD_TOP), .STEP(MAIN_STEP), .HEAD_LEN('0)) old_rule_i (
        .addr (acc_addr), .cut (fld.old_cut), .head_en (1'b0), .deny (rule_deny[0])
    );

    dmaprot_cutoff_rule #(.ADDR_W(ADDR_W), .CW(NEW_CW), .BASE(NEW_BASE),
        .TOP(NEW_TOP), .STEP(MAIN_STEP), .HEAD_LEN(MAIN_STEP)) new_rule_i (
        .addr (acc_addr), .cut (fld.new_cut), .head_en (fld.old_cut != '0),
        .deny (rule_deny[1])
    );

    dmaprot_cutoff_rule #(.ADDR_W(ADDR_W), .CW(SEC_CW), .BASE(SEC_BASE),
        .TOP(SEC_TOP), .STEP(SEC_STEP), .HEAD_LEN('0)) sec_rule_i (
        .addr (acc_addr), .cut (fld.sec_cut), .head_en (1'b0), .deny (rule_deny[2])
    );

    dmaprot_window_rule #(.ADDR_W(ADDR_W), .BASE(WRAM_BASE), .TOP(WRAM_TOP)) wram_rule_i (
        .addr (acc_addr), .lock (fld.wram_lock), .deny (rule_deny[3])
    );

    // Any single rule refuses the access.
    always_comb deny_any = |rule_deny;

    // Register the verdict alongside its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_deny  <= 1'b0;
        end else begin
            chk_valid <= acc_valid;
            chk_deny  <= acc_valid && deny_any;
        end
    end

    // Region classification used only by the checks below.
    always_comb begin
        a_ext       = {1'b0, acc_addr};
        outside_all = !((a_ext >= OLD_BASE)  && (a_ext < OLD_TOP))  &&
                      !((a_ext >= NEW_BASE)  && (a_ext < NEW_TOP))  &&
                      !((a_ext >= SEC_BASE)  && (a_ext < SEC_TOP))  &&
                      !((a_ext >= WRAM_BASE) && (a_ext < WRAM_TOP));
        old_head    = (a_ext >= OLD_BASE) && (a_ext < OLD_BASE + MAIN_STEP);
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> chk_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!chk_valid && !chk_deny));

    // R8
    old_head_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && old_head) |=> !chk_deny);

    // R9
    outside_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && outside_all) |=> !chk_deny);

    // R2 R11
    zero_cfg_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg_rd_data == '0) |=> !chk_deny);
endmodule

// File: tb/dmaprot_guard_tb.sv
`timescale 1ns/1ps
module dmaprot_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [31:0] cfg_wr_data;
    logic [31:0] cfg_rd_data;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic        chk_valid;
    logic        chk_deny;

    always #10 clk = ~clk;

    dmaprot_guard dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr_en (cfg_wr_en), .cfg_wr_data (cfg_wr_data), .cfg_rd_data (cfg_rd_data),
        .acc_valid (acc_valid), .acc_addr (acc_addr),
        .chk_valid (chk_valid), .chk_deny (chk_deny)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    bit    model_live = 0;
    logic [31:0] mreg;
    bit    exp_v, exp_d;
    string cur_tag = "R2";

    // Behavioural verdict from the requirement text.
    function automatic bit ref_deny(longint a, longint r);
        longint x = r & 15, y = (r >> 4) & 15, w = (r >> 8) & 1, z = (r >> 9) & 3;
        bit d = 0;
        if (x != 0 && a >= 64'h2800_0000 - 64'h80_0000 * x && a < 64'h2800_0000) d = 1;
        if (y != 0 && a >= 64'h3000_0000 - 64'h80_0000 * y && a < 64'h3000_0000) d = 1;
        if (x != 0 && a >= 64'h2800_0000 && a < 64'h2880_0000) d = 1;
        if (w != 0 && a >= 64'h1FF8_0000 && a < 64'h2000_0000) d = 1;
        if (z != 0 && a >= 64'h1F40_0000 - 64'h10_0000 * z && a < 64'h1F40_0000) d = 1;
        return d;
    endfunction

    // Model: judge with the pre-write value, then apply the write.
    always @(posedge clk) begin
        model_live = 1;
        if (!rst_n) begin
            exp_v = 0; exp_d = 0; mreg = 0;
        end else begin
            exp_v = acc_valid;
            exp_d = acc_valid && ref_deny(longint'(acc_addr), longint'(mreg));
            if (cfg_wr_en) mreg = cfg_wr_data & 32'h7FF;
        end
    end

    task automatic check_now();
        if (!model_live) return;
        n_vec++;
        if (chk_valid !== exp_v) begin
            n_bad++;
            $display("FAIL %s: chk_valid %0b expected %0b", cur_tag, chk_valid, exp_v);
        end
        if (chk_deny !== exp_d) begin
            n_bad++;
            $display("FAIL %s: chk_deny %0b expected %0b (addr of prior access)", cur_tag, chk_deny, exp_d);
        end
        if (cfg_rd_data !== mreg) begin
            n_bad++;
            $display("FAIL %s: cfg_rd_data %h expected %h", cur_tag, cfg_rd_data, mreg);
        end
    endtask

    task automatic drive(input bit wr, input logic [31:0] wd, input bit av,
                         input logic [31:0] ad, input string tag);
        @(negedge clk);
        check_now();
        cfg_wr_en = wr; cfg_wr_data = wd; acc_valid = av; acc_addr = ad;
        cur_tag = tag;
    endtask

    task automatic probe(input logic [31:0] ad, input string tag);
        drive(0, 32'h0, 1, ad, tag);
    endtask

    task automatic wr(input logic [31:0] v, input string tag);
        drive(1, v, 0, 32'h0, tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_wr_en = 0; cfg_wr_data = '0; acc_valid = 0; acc_addr = '0;
        repeat (3) @(negedge clk);
        check_now();                       // R2 reset state
        rst_n = 1;
        // R2: zero register opens every region
        probe(32'h27FF_FFFF, "R2"); probe(32'h2FFF_FFFF, "R2");
        probe(32'h1F3F_FFFF, "R2"); probe(32'h1FFF_FFFF, "R2");
        // R1: upper bits dropped, stored bits read back
        wr(32'hFFFF_FFFF, "R1"); drive(0, 0, 0, 0, "R1");
        wr(32'hA5A5_A000, "R1"); drive(0, 0, 0, 0, "R1");
        // R3, R5, R8: old cutoff sweep
        for (int x = 1; x < 16; x++) begin
            logic [31:0] st;
            st = 32'h2800_0000 - 32'h80_0000 * x;
            wr(32'(x), "R3");
            probe(st - 1, "R3"); probe(st, "R3"); probe(32'h27FF_FFFF, "R3");
            probe(32'h2800_0000, "R5"); probe(32'h287F_FFFF, "R5"); probe(32'h2880_0000, "R5");
            probe(32'h2000_0000, "R8"); probe(32'h207F_FFFF, "R8");
        end
        // R4: extension cutoff sweep
        for (int y = 1; y < 16; y++) begin
            logic [31:0] st;
            st = 32'h3000_0000 - 32'h80_0000 * y;
            wr(32'(y) << 4, "R4");
            probe(st - 1, "R4"); probe(st, "R4"); probe(32'h2FFF_FFFF, "R4");
            probe(32'h3000_0000, "R9"); probe(32'h2800_0000, "R5");
        end
        // R6: work-RAM lock
        wr(32'h100, "R6");
        probe(32'h1FF7_FFFF, "R6"); probe(32'h1FF8_0000, "R6"); probe(32'h1FFF_FFFF, "R6");
        wr(32'h0, "R6"); probe(32'h1FF8_0000, "R6");
        // R7: secondary cutoff sweep
        for (int z = 1; z < 4; z++) begin
            logic [31:0] st;
            st = 32'h1F40_0000 - 32'h10_0000 * z;
            wr(32'(z) << 9, "R7");
            probe(st - 1, "R7"); probe(st, "R7"); probe(32'h1F3F_FFFF, "R7");
            probe(32'h1F40_0000, "R7"); probe(32'h1F00_0000, "R7");
        end
        // R9: everything active together
        wr(32'h7FF, "R9");
        probe(32'h0000_0000, "R9"); probe(32'h1EFF_FFFF, "R9"); probe(32'h1F0F_FFFF, "R9");
        probe(32'h1F10_0000, "R9"); probe(32'h1FF7_FFFF, "R9"); probe(32'h2000_0000, "R9");
        probe(32'h207F_FFFF, "R9"); probe(32'h2080_0000, "R9"); probe(32'h2FFF_FFFF, "R9");
        probe(32'h3000_0000, "R9"); probe(32'hFFFF_FFFF, "R9"); probe(32'h2840_0000, "R9");
        // R11: write and access on the same edge
        wr(32'h0, "R11");
        drive(1, 32'h00F, 1, 32'h27FF_FFFF, "R11");
        drive(1, 32'h000, 1, 32'h27FF_FFFF, "R11");
        probe(32'h27FF_FFFF, "R11");
        // R10: alternating access and idle cycles
        wr(32'h001, "R10");
        probe(32'h27FF_FFFF, "R10"); drive(0, 0, 0, 32'h27FF_FFFF, "R10");
        probe(32'h27FF_FFFF, "R10"); drive(0, 0, 0, 32'h0, "R10");
        probe(32'h1000_0000, "R10");
        drive(0, 0, 0, 0, "R10");
        drive(0, 0, 0, 0, "R10");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule